// File: doc/BRIEF.md
# Paged ROM and Keyboard Select Logic

This block decides what answers a CPU read in the 16 KB paged window at 0x8000–0xBFFF. A 4-bit slot number, written by the CPU into a paging register, picks one of sixteen slots. Slots 10 and 11 enable an on-chip language ROM. Slots 8 and 9 turn the window into a keyboard port: the low fourteen address lines strobe the keyboard columns and the four row lines come back on the data bus. Slots 0 to 7 enable one of eight external ROMs. Slots 12 to 15 enable nothing here and serve as the parking state that releases the language ROM.

A low slot (0 to 7) can only be reached in two steps. A write with the enable bit (bit 3) set moves the register to a high slot, 12 to 15. Only from there, or from a slot that is already external, does a write with bit 3 clear take effect. While slots 8 to 11 are held, such a request is dropped. The chip selects and the keyboard data are combinational from the registered slot and the current bus inputs, so a read sees the new slot in the cycle after the write.

Top module: `pgsel_top`

## Requirements
- R1: Holding rst_n low at a clock edge sets the slot to 10, so the first window read after reset asserts lang_cs.
- R2: No select, column strobe or keyboard data is driven unless rd_en is 1 and cpu_addr[15:14] is 2'b10.
- R3: With the slot at 10 or 11, a window read asserts lang_cs only.
- R4: With the slot at 8 or 9, a window read drives kb_col[i]=1 exactly where cpu_addr[i]=0 for i in 0..13, and kb_rd_data={4'b0000, kb_row_in}. Slots 8 and 9 behave identically.
- R5: A write with pg_wdata[3]=1 always loads pg_wdata[3:0] into the slot. The new slot takes effect in the next cycle.
- R6: A write with pg_wdata[3]=0, made while the slot is 0–7 or 12–15, loads slot {1'b0, pg_wdata[2:0]}. A window read in slot n<8 then asserts ext_cs, with ext_sel=n.
- R7: A write with pg_wdata[3]=0, made while the slot is 8–11, leaves the slot unchanged.
- R8: With the slot at 12–15, a window read asserts none of lang_cs, ext_cs or the keyboard outputs, and ext_sel is 0.
- R9: pg_wdata[7:4] has no effect on the slot.
- R10: Outside a keyboard read, kb_col and kb_rd_data are all zeros. ext_sel is 0 whenever the slot is 8–15.
- R11: At most one of lang_cs, ext_cs and the keyboard read is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pg_wr | input | 1 | Write strobe for the paging register |
| pg_wdata | input | 8 | Write data; bits 3:0 hold the slot request |
| rd_en | input | 1 | CPU read cycle |
| cpu_addr | input | 16 | CPU address |
| kb_row_in | input | 4 | Keyboard row lines |
| lang_cs | output | 1 | Internal language ROM select |
| ext_cs | output | 1 | External ROM select |
| ext_sel | output | 3 | External ROM number 0 to 7 |
| kb_col | output | 14 | Keyboard column strobes, active high |
| kb_rd_data | output | 8 | Keyboard read data |

## Verification
Directed write sequences try low requests from every slot class: the language slots, the keyboard slots, a parking slot and an already-external slot. This separates a design that enforces the two-step rule from one that accepts or rejects low requests everywhere. Reads are made inside and outside the window, and with rd_en low, so a decoder that checks too few address bits shows up. Walking-zero and mixed address patterns with varied row data show whether each column and row line is wired to its own bit. A long randomized stretch with upper data bits set is compared every cycle against a behavioural slot model. It also catches ordering faults between the write and the read paths.

// File: rtl/pgsel_pkg.sv
// Package: shared types and constants for the paged slot selector.
// Assumes a 4-bit slot number whose bit 3 is the enable flag.
package pgsel_pkg;

    localparam int SLOT_W = 4;
    localparam int EN_BIT = SLOT_W - 1;
    localparam logic [SLOT_W-1:0] SLOT_RESET = 4'd10;

    typedef enum logic [1:0] {
        SC_EXT  = 2'd0,
        SC_KBD  = 2'd1,
        SC_LANG = 2'd2,
        SC_PARK = 2'd3
    } slot_class_e;

    // Map a slot number to its class: 0-7 ext, 8-9 kbd, 10-11 lang, 12-15 park
    function automatic slot_class_e classify(input logic [SLOT_W-1:0] s);
        if (!s[EN_BIT])
            return SC_EXT;
        case (s[2:1])
            2'b00:   return SC_KBD;
            2'b01:   return SC_LANG;
            default: return SC_PARK;
        endcase
    endfunction

endpackage

// File: rtl/pgsel_slot_reg.sv
// Module: paging slot register.
// Holds the selected slot and applies the two-step rule: a request with the
// enable bit clear is only taken while the slot is external or parked.
// Assumes writes are single-cycle strobes; reset is synchronous, active low.
module pgsel_slot_reg
    import pgsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    output logic [SLOT_W-1:0] slot_q,
    output slot_class_e       slot_cls
);

    logic        low_ok;
    logic        take;
    slot_class_e cur_cls;

    // Classify the slot currently held
    always_comb cur_cls = classify(slot_q);

    // Decide whether this write is accepted
    always_comb begin
        low_ok = (cur_cls == SC_EXT) || (cur_cls == SC_PARK);
        take   = wr_en && (wr_slot[EN_BIT] || low_ok);
    end

    // Load the slot on an accepted write
    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_q <= SLOT_RESET;
        else if (take)
            slot_q <= wr_slot[EN_BIT] ? wr_slot : {1'b0, wr_slot[EN_BIT-1:0]};
    end

    assign slot_cls = cur_cls;

    // R5
    hi_write_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_slot[EN_BIT]) |=> (slot_q == $past(wr_slot)));

    // R7
    low_req_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_slot[EN_BIT] && slot_q[EN_BIT] && !slot_q[2]) |=> $stable(slot_q));

    // R6
    low_req_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_slot[EN_BIT] && (!slot_q[EN_BIT] || slot_q[2]))
            |=> (slot_q[EN_BIT] == 1'b0));

endmodule

// File: rtl/pgsel_win_dec.sv
// Module: paged window decoder.
// Turns the slot class and the top two address bits into one select.
// Assumes the window is the quarter of the address space with top bits 2'b10.
module pgsel_win_dec
    import pgsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [1:0]        win_bits,
    input  logic [SLOT_W-1:0] slot_q,
    input  slot_class_e       slot_cls,
    output logic              lang_cs,
    output logic              ext_cs,
    output logic [2:0]        ext_sel,
    output logic              kb_sel
);

    logic in_win;

    // Detect a read inside the paged window
    always_comb in_win = rd_en && (win_bits == 2'b10);

    // Drive exactly one select for the current slot class
    always_comb begin
        lang_cs = in_win && (slot_cls == SC_LANG);
        ext_cs  = in_win && (slot_cls == SC_EXT);
        kb_sel  = in_win && (slot_cls == SC_KBD);
    end

    // Present the external ROM number only for external slots
    always_comb ext_sel = (slot_cls == SC_EXT) ? slot_q[2:0] : 3'd0;

    // R11
    one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lang_cs, ext_cs, kb_sel}));

    // R8
    park_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_q[EN_BIT] && slot_q[2]) |-> !(lang_cs || ext_cs || kb_sel) && (ext_sel == 3'd0));

    // R2
    outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && win_bits == 2'b10) |-> !(lang_cs || ext_cs || kb_sel));

endmodule

// File: rtl/pgsel_kbd_port.sv
// Module: keyboard port.
// Strobes each column whose address line is low and returns the row lines
// on the low data bits. Assumes kb_sel is only high during a window read.
module pgsel_kbd_port #(
    parameter int COLS   = 14,
    parameter int ROWS   = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              kb_sel,
    input  logic [COLS-1:0]   col_addr,
    input  logic [ROWS-1:0]   row_in,
    output logic [COLS-1:0]   col_drv,
    output logic [DATA_W-1:0] rd_data
);

    localparam int PAD_W = DATA_W - ROWS;

    // One strobe per column, active while its address line is low
    for (genvar c = 0; c < COLS; c++) begin : g_col
        assign col_drv[c] = kb_sel & ~col_addr[c];
    end

    // Return the row lines with the upper bits held at zero
    always_comb rd_data = kb_sel ? {{PAD_W{1'b0}}, row_in} : '0;

    // R10
    kbd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !kb_sel |-> (col_drv == '0) && (rd_data == '0));

    // R4
    kbd_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kb_sel |-> (rd_data[DATA_W-1:ROWS] == '0) && (rd_data[ROWS-1:0] == row_in));

endmodule

// File: rtl/pgsel_top.sv
// Module: paged ROM and keyboard select top.
// Joins the slot register, the window decoder and the keyboard port.
// Assumes the paged window is 0x8000-0xBFFF and the slot request is in the
// low nibble of the paging write; upper write bits belong to other logic.
module pgsel_top #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int KB_COLS = 14,
    parameter int KB_ROWS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pg_wr,
    input  logic [DATA_W-1:0]  pg_wdata,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic [KB_ROWS-1:0] kb_row_in,
    output logic               lang_cs,
    output logic               ext_cs,
    output logic [2:0]         ext_sel,
    output logic [KB_COLS-1:0] kb_col,
    output logic [DATA_W-1:0]  kb_rd_data
);
    import pgsel_pkg::*;

    logic [SLOT_W-1:0] slot_q;
    slot_class_e       slot_cls;
    logic              kb_sel;
    logic              unused_wdata_hi;

    // Upper write bits serve other registers at this address
    assign unused_wdata_hi = ^pg_wdata[DATA_W-1:SLOT_W];

    pgsel_slot_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (pg_wr),
        .wr_slot  (pg_wdata[SLOT_W-1:0]),
        .slot_q   (slot_q),
        .slot_cls (slot_cls)
    );

    pgsel_win_dec u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .win_bits (cpu_addr[ADDR_W-1:ADDR_W-2]),
        .slot_q   (slot_q),
        .slot_cls (slot_cls),
        .lang_cs  (lang_cs),
        .ext_cs   (ext_cs),
        .ext_sel  (ext_sel),
        .kb_sel   (kb_sel)
    );

    pgsel_kbd_port #(
        .COLS   (KB_COLS),
        .ROWS   (KB_ROWS),
        .DATA_W (DATA_W)
    ) u_kbd (
        .clk      (clk),
        .rst_n    (rst_n),
        .kb_sel   (kb_sel),
        .col_addr (cpu_addr[KB_COLS-1:0]),
        .row_in   (kb_row_in),
        .col_drv  (kb_col),
        .rd_data  (kb_rd_data)
    );

    // R4
    kbd_col_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kb_sel |-> (kb_col == ~cpu_addr[KB_COLS-1:0]));

    // R1
    reset_lang_chk: assert property (@(posedge clk)
        !rst_n |=> (slot_q == SLOT_RESET));

endmodule

// File: tb/pgsel_top_tb.sv
`timescale 1ns/1ps
module pgsel_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pg_wr = 1'b0;
    logic [7:0]  pg_wdata = 8'h00;
    logic        rd_en = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [3:0]  kb_row_in = 4'h0;
    logic        lang_cs, ext_cs;
    logic [2:0]  ext_sel;
    logic [13:0] kb_col;
    logic [7:0]  kb_rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    int mslot = 10;

    always #2.5 clk = ~clk;

    pgsel_top u_dut (
        .clk(clk), .rst_n(rst_n), .pg_wr(pg_wr), .pg_wdata(pg_wdata),
        .rd_en(rd_en), .cpu_addr(cpu_addr), .kb_row_in(kb_row_in),
        .lang_cs(lang_cs), .ext_cs(ext_cs), .ext_sel(ext_sel),
        .kb_col(kb_col), .kb_rd_data(kb_rd_data)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
        end
    endtask

    // Compare all outputs against the behavioural slot model
    task automatic compare(input string tag);
        bit win, kb;
        int exp_col, exp_dat;
        win = rd_en && (cpu_addr >= 16'h8000) && (cpu_addr < 16'hC000);
        kb  = win && (mslot == 8 || mslot == 9);
        exp_col = 0;
        for (int i = 0; i < 14; i++)
            if (kb && cpu_addr[i] == 1'b0) exp_col += (1 << i);
        exp_dat = kb ? int'(kb_row_in) : 0;
        chk({tag, "/R3"}, "lang_cs", int'(lang_cs), int'(win && (mslot == 10 || mslot == 11)));
        chk({tag, "/R6"}, "ext_cs", int'(ext_cs), int'(win && mslot < 8));
        chk({tag, "/R10"}, "ext_sel", int'(ext_sel), (mslot < 8) ? mslot : 0);
        chk({tag, "/R4"}, "kb_col", int'(kb_col), exp_col);
        chk({tag, "/R4"}, "kb_rd_data", int'(kb_rd_data), exp_dat);
        chk({tag, "/R11"}, "selects", int'(lang_cs) + int'(ext_cs) + int'(kb_col != 0 || kb_rd_data != 0) > 1 ? 1 : 0, 0);
    endtask

    // One bus cycle: drive, compare mid-cycle, then apply the write at the edge
    task automatic cycle(input string tag, input bit wr, input logic [7:0] d,
                         input bit rd, input logic [15:0] a, input logic [3:0] rows);
        pg_wr = wr; pg_wdata = d; rd_en = rd; cpu_addr = a; kb_row_in = rows;
        #1.5;
        compare(tag);
        @(posedge clk);
        if (wr) begin
            if (d[3]) mslot = int'(d[3:0]);
            else if (mslot < 8 || mslot >= 12) mslot = int'(d[2:0]);
        end
        #1;
    endtask

    task automatic rd(input string tag, input logic [15:0] a, input logic [3:0] rows);
        cycle(tag, 1'b0, 8'h00, 1'b1, a, rows);
    endtask

    task automatic wr(input string tag, input logic [7:0] d);
        cycle(tag, 1'b1, d, 1'b0, 16'h0000, 4'h0);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        mslot = 10;
        // R1: reset leaves the language ROM selected
        rd("R1", 16'h8000, 4'h0);
        chk("R1", "lang_cs after reset", int'(lang_cs), 1);
        // R2: outside the window or without rd_en nothing is selected
        rd("R2", 16'h7FFF, 4'hF);
        rd("R2", 16'hC000, 4'hF);
        cycle("R2", 1'b0, 8'h00, 1'b0, 16'h9000, 4'hF);
        // R7: low request from language slot is dropped
        wr("R7", 8'h05);
        rd("R7", 16'hA000, 4'h0);
        chk("R7", "lang still selected", int'(lang_cs), 1);
        // R5/R3: slot 11
        wr("R5", 8'h0B);
        rd("R3", 16'hBFFF, 4'h0);
        // R4: keyboard via slot 9 and 8 with walking zeros
        wr("R5", 8'h09);
        for (int i = 0; i < 14; i++) rd("R4", 16'hBFFF & ~(16'h1 << i), 4'(i));
        rd("R4", 16'h8000, 4'hA);
        chk("R4", "all columns", int'(kb_col), 14'h3FFF);
        // R7: low request from keyboard slot is dropped
        wr("R7", 8'h02);
        rd("R7", 16'h9555, 4'h5);
        chk("R7", "kbd still active", int'(kb_rd_data), 8'h05);
        wr("R9", 8'hF8);
        rd("R9", 16'hAAAA, 4'h3);
        wr("R7", 8'h01);
        rd("R7", 16'h8123, 4'hC);
        // R8: park slot
        wr("R8", 8'h0C);
        rd("R8", 16'h8000, 4'hF);
        chk("R8", "no select", int'(lang_cs | ext_cs | (kb_col != 0)), 0);
        // R6: low request from park slot taken
        wr("R6", 8'h03);
        rd("R6", 16'h8000, 4'hF);
        chk("R6", "ext_sel", int'(ext_sel), 3);
        // R6/R9: from external slot, upper bits ignored
        wr("R9", 8'hA6);
        rd("R9", 16'hB000, 4'h0);
        chk("R9", "ext_sel", int'(ext_sel), 6);
        wr("R6", 8'h00);
        rd("R6", 16'h8000, 4'h0);
        wr("R5", 8'h0F);
        wr("R6", 8'h07);
        rd("R6", 16'hBFFF, 4'h0);
        // R10: ext_sel zero for high slots
        wr("R10", 8'h0A);
        rd("R10", 16'h8000, 4'h0);
        // Random stretch
        for (int n = 0; n < 2000; n++) begin
            cycle("RND", 1'($urandom_range(0, 3) == 0), 8'($urandom),
                  1'($urandom), 16'($urandom), 4'($urandom));
        end
        // R1: reset mid-run returns to the language slot
        wr("R1", 8'h0C);
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        mslot = 10;
        rd("R1", 16'h8000, 4'h0);
        chk("R1", "lang after re-reset", int'(lang_cs), 1);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule